// File: doc/BRIEF.md
# Trap Entry and Shadow-State Unit

This unit owns the trap-sensitive architectural state of a small multithreaded core: the general and predicate registers of thread 0, the program counter, the active-thread count, the interrupt-enable bit and the supervisor bit. During normal operation the core updates this state through plain write ports and reads it back combinationally. When a trap request arrives and traps are enabled, one clock edge copies all of that state into a single shadow bank and puts the core into a fixed handler state: one thread, supervisor mode, traps off, PC at a programmable handler address.

Three kinds of request can arrive: a page fault (with a flag for "page missing" and the faulting address), a divergent branch and a domain error. Only one is accepted per cycle, by fixed priority. The accepted cause code goes into general register 0. A page fault also puts the faulting address into general register 1. The live PC holds the already-advanced address of the next instruction. For page faults and divergent branches the saved PC is wound back by the instruction length that comes with the request, so the faulting instruction runs again. A domain error saves the live PC as it is. A core whose active-thread count is zero is halted, and the unit then freezes.

Top module: `trap_shadow_unit`

## Requirements
- R1: After reset the PC is 0, traps are disabled, supervisor mode is on, the active-thread count is 1, the handler address is 0, general register 0 holds NTHREADS in its upper half-word and CORE_ID in its lower half-word, and all other general and predicate registers are 0.
- R2: Each write port (general register, predicate, PC, interrupt-enable, supervisor, thread count, handler address) updates its state on the clock edge at which its enable is sampled. General register reads are combinational from the read address.
- R3: While interrupt-enable is 0, trap requests are ignored. No taken pulse is produced and no state changes.
- R4: `trapTaken` is high for exactly the one cycle that follows the edge at which a trap was accepted.
- R5: On acceptance the shadow bank receives the pre-trap values of every general register, every predicate bit, the active-thread count, interrupt-enable and supervisor.
- R6: After acceptance the active-thread count is 1, interrupt-enable is 0, supervisor is 1 and the PC equals the handler address.
- R7: On acceptance general register 0 is loaded with the zero-extended cause code: 1 for a page fault with the page missing, 2 for any other page fault, 4 for a divergent branch, 5 for a domain error.
- R8: A page-fault entry writes `pfAddr` into general register 1. Other causes leave general register 1 unchanged.
- R9: The saved PC is the live PC minus `instLen` for page faults and divergent branches, and the live PC unchanged for domain errors.
- R10: When several requests are raised in one cycle, a page fault wins over a divergent branch, which wins over a domain error.
- R11: While the active-thread count is 0, trap requests and all write ports are ignored and the state stays frozen.
- R12: Ordinary write-port updates presented in the same cycle as an accepted trap are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pfReq | input | 1 | Page-fault trap request |
| pfMissing | input | 1 | Page fault is for a missing page (otherwise a protection fault) |
| pfAddr | input | W | Faulting address |
| divReq | input | 1 | Divergent-branch trap request |
| domReq | input | 1 | Domain-error trap request |
| instLen | input | LENW | Length of the trapping instruction |
| rfWe | input | 1 | General register write enable |
| rfWaddr | input | RAW | General register write index |
| rfWdata | input | W | General register write data |
| rfRaddr | input | RAW | Live general register read index |
| rfRdata | output | W | Live general register read data |
| predWe | input | 1 | Predicate write enable |
| predWaddr | input | PAW | Predicate write index |
| predWdata | input | 1 | Predicate write value |
| predOut | output | NPRED | Live predicate bits |
| pcWe | input | 1 | PC write enable |
| pcWdata | input | W | Next PC value |
| ieWe | input | 1 | Interrupt-enable write enable |
| ieWdata | input | 1 | Interrupt-enable value |
| svWe | input | 1 | Supervisor write enable |
| svWdata | input | 1 | Supervisor value |
| thrWe | input | 1 | Active-thread count write enable |
| thrWdata | input | TW | Active-thread count value |
| handlerWe | input | 1 | Handler address write enable |
| handlerWdata | input | W | Handler address value |
| trapTaken | output | 1 | One-cycle pulse after trap acceptance |
| pcOut | output | W | Live PC |
| ieOut | output | 1 | Live interrupt-enable |
| supervisorOut | output | 1 | Live supervisor bit |
| activeThreadsOut | output | TW | Live active-thread count |
| shRaddr | input | RAW | Shadow general register read index |
| shRdata | output | W | Shadow general register read data |
| shPredOut | output | NPRED | Shadow predicate bits |
| shPcOut | output | W | Saved PC |
| shIeOut | output | 1 | Saved interrupt-enable |
| shSvOut | output | 1 | Saved supervisor bit |
| shThreadsOut | output | TW | Saved active-thread count |

## Verification
The hardest case to reach from the ports is an accepted trap whose saved state differs in every field from both the reset values and the handler state. In that case a missed copy or a copy taken one edge late can be told apart from a correct one. Before each trap the stimulus drives every write port in one cycle: traps on, supervisor off, several threads, a distinct PC and handler, marked registers. It then raises the request, sometimes together with lower-priority requests and a conflicting register write, so that the priority logic and the discarding of ordinary writes are exercised in the same edge. The frozen state of a halted core can only be reached by writing a zero thread count, so that test runs last.

// File: rtl/trap_pkg.sv
package trap_pkg;

  // Cause codes written into general register 0 on trap entry
  typedef enum logic [2:0] {
    CAUSE_NONE       = 3'd0,
    CAUSE_PG_MISSING = 3'd1,
    CAUSE_PG_OTHER   = 3'd2,
    CAUSE_DIVERGE    = 3'd4,
    CAUSE_DOMAIN     = 3'd5
  } trapCause_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       take;      // capture shadow bank, enter handler state
    logic       loadAddr;  // write fault address into register 1
    logic       rewind;    // subtract instruction length from saved PC
    logic       wrEn;      // ordinary write ports may update state
    trapCause_e cause;
  } trapStrobe_t;

endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pfReq,
  input  logic        pfMissing,
  input  logic        divReq,
  input  logic        domReq,
  input  logic        ieCur,
  input  logic        haltCur,
  output trapStrobe_t strobe,
  output logic        trapTaken
);

  logic       anyReq;
  logic       takeNow;
  trapCause_e causeSel;

  assign anyReq  = pfReq | divReq | domReq;
  assign takeNow = anyReq & ieCur & ~haltCur;

  // Fixed priority: page fault, then divergent branch, then domain error
  always_comb begin
    causeSel = CAUSE_NONE;
    if (pfReq)       causeSel = pfMissing ? CAUSE_PG_MISSING : CAUSE_PG_OTHER;
    else if (divReq) causeSel = CAUSE_DIVERGE;
    else if (domReq) causeSel = CAUSE_DOMAIN;
  end

  always_comb begin
    strobe.take     = takeNow;
    strobe.loadAddr = takeNow & pfReq;
    strobe.rewind   = takeNow & (pfReq | divReq);
    strobe.wrEn     = ~haltCur & ~takeNow;
    strobe.cause    = causeSel;
  end

  logic takenQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) takenQ <= 1'b0;
    else       takenQ <= takeNow;
  end
  assign trapTaken = takenQ;

endmodule

// File: rtl/trap_state_dp.sv
module trap_state_dp
  import trap_pkg::*;
#(
  parameter int W        = 32,
  parameter int NREG     = 8,
  parameter int NPRED    = 4,
  parameter int NTHREADS = 4,
  parameter int CORE_ID  = 0,
  parameter int LENW     = 4,
  localparam int RAW     = $clog2(NREG),
  localparam int PAW     = $clog2(NPRED),
  localparam int TW      = $clog2(NTHREADS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  trapStrobe_t      strobe,
  input  logic [W-1:0]     pfAddr,
  input  logic [LENW-1:0]  instLen,
  input  logic             rfWe,
  input  logic [RAW-1:0]   rfWaddr,
  input  logic [W-1:0]     rfWdata,
  input  logic [RAW-1:0]   rfRaddr,
  output logic [W-1:0]     rfRdata,
  input  logic             predWe,
  input  logic [PAW-1:0]   predWaddr,
  input  logic             predWdata,
  output logic [NPRED-1:0] predOut,
  input  logic             pcWe,
  input  logic [W-1:0]     pcWdata,
  input  logic             ieWe,
  input  logic             ieWdata,
  input  logic             svWe,
  input  logic             svWdata,
  input  logic             thrWe,
  input  logic [TW-1:0]    thrWdata,
  input  logic             handlerWe,
  input  logic [W-1:0]     handlerWdata,
  output logic [W-1:0]     pcOut,
  output logic             ieOut,
  output logic             supervisorOut,
  output logic [TW-1:0]    activeThreadsOut,
  output logic             haltCur,
  input  logic [RAW-1:0]   shRaddr,
  output logic [W-1:0]     shRdata,
  output logic [NPRED-1:0] shPredOut,
  output logic [W-1:0]     shPcOut,
  output logic             shIeOut,
  output logic             shSvOut,
  output logic [TW-1:0]    shThreadsOut
);

  localparam int HALF = W / 2;
  localparam logic [W-1:0] RESET_R0 =
    (W'(NTHREADS) << HALF) | (W'(CORE_ID) & ((W'(1) << HALF) - W'(1)));

  logic [W-1:0]     regQ   [NREG];
  logic [W-1:0]     shRegQ [NREG];
  logic [NPRED-1:0] predQ, shPredQ;
  logic [W-1:0]     pcQ, shPcQ, handlerQ;
  logic             ieQ, svQ, shIeQ, shSvQ;
  logic [TW-1:0]    thrQ, shThrQ;
  logic [W-1:0]     savedPc;

  assign savedPc = strobe.rewind ? (pcQ - W'(instLen)) : pcQ;

  // General registers of thread 0 and their shadows
  for (genvar g = 0; g < NREG; g++) begin : gReg
    logic [W-1:0] rstVal;
    logic         hitTrap;
    logic [W-1:0] trapVal;
    if (g == 0) begin : gR0
      assign rstVal  = RESET_R0;
      assign hitTrap = 1'b1;
      assign trapVal = W'(strobe.cause);
    end else if (g == 1) begin : gR1
      assign rstVal  = '0;
      assign hitTrap = strobe.loadAddr;
      assign trapVal = pfAddr;
    end else begin : gRn
      assign rstVal  = '0;
      assign hitTrap = 1'b0;
      assign trapVal = '0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regQ[g] <= rstVal;
      end else if (strobe.take) begin
        if (hitTrap) regQ[g] <= trapVal;
      end else if (strobe.wrEn && rfWe && (rfWaddr == RAW'(g))) begin
        regQ[g] <= rfWdata;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            shRegQ[g] <= '0;
      else if (strobe.take) shRegQ[g] <= regQ[g];
    end
  end

  // Predicate registers of thread 0
  for (genvar p = 0; p < NPRED; p++) begin : gPred
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        predQ[p]   <= 1'b0;
        shPredQ[p] <= 1'b0;
      end else if (strobe.take) begin
        shPredQ[p] <= predQ[p];
      end else if (strobe.wrEn && predWe && (predWaddr == PAW'(p))) begin
        predQ[p] <= predWdata;
      end
    end
  end

  // Scalar control state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ      <= '0;
      ieQ      <= 1'b0;
      svQ      <= 1'b1;
      thrQ     <= TW'(1);
      handlerQ <= '0;
      shPcQ    <= '0;
      shIeQ    <= 1'b0;
      shSvQ    <= 1'b0;
      shThrQ   <= '0;
    end else if (strobe.take) begin
      shPcQ  <= savedPc;
      shIeQ  <= ieQ;
      shSvQ  <= svQ;
      shThrQ <= thrQ;
      pcQ    <= handlerQ;
      ieQ    <= 1'b0;
      svQ    <= 1'b1;
      thrQ   <= TW'(1);
    end else if (strobe.wrEn) begin
      if (pcWe)      pcQ      <= pcWdata;
      if (ieWe)      ieQ      <= ieWdata;
      if (svWe)      svQ      <= svWdata;
      if (thrWe)     thrQ     <= thrWdata;
      if (handlerWe) handlerQ <= handlerWdata;
    end
  end

  assign rfRdata          = regQ[rfRaddr];
  assign predOut          = predQ;
  assign pcOut            = pcQ;
  assign ieOut            = ieQ;
  assign supervisorOut    = svQ;
  assign activeThreadsOut = thrQ;
  assign haltCur          = (thrQ == '0);
  assign shRdata          = shRegQ[shRaddr];
  assign shPredOut        = shPredQ;
  assign shPcOut          = shPcQ;
  assign shIeOut          = shIeQ;
  assign shSvOut          = shSvQ;
  assign shThreadsOut     = shThrQ;

endmodule

// File: rtl/trap_shadow_unit.sv
module trap_shadow_unit
  import trap_pkg::*;
#(
  parameter int W        = 32,
  parameter int NREG     = 8,
  parameter int NPRED    = 4,
  parameter int NTHREADS = 4,
  parameter int CORE_ID  = 0,
  parameter int LENW     = 4,
  localparam int RAW     = $clog2(NREG),
  localparam int PAW     = $clog2(NPRED),
  localparam int TW      = $clog2(NTHREADS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pfReq,
  input  logic             pfMissing,
  input  logic [W-1:0]     pfAddr,
  input  logic             divReq,
  input  logic             domReq,
  input  logic [LENW-1:0]  instLen,
  input  logic             rfWe,
  input  logic [RAW-1:0]   rfWaddr,
  input  logic [W-1:0]     rfWdata,
  input  logic [RAW-1:0]   rfRaddr,
  output logic [W-1:0]     rfRdata,
  input  logic             predWe,
  input  logic [PAW-1:0]   predWaddr,
  input  logic             predWdata,
  output logic [NPRED-1:0] predOut,
  input  logic             pcWe,
  input  logic [W-1:0]     pcWdata,
  input  logic             ieWe,
  input  logic             ieWdata,
  input  logic             svWe,
  input  logic             svWdata,
  input  logic             thrWe,
  input  logic [TW-1:0]    thrWdata,
  input  logic             handlerWe,
  input  logic [W-1:0]     handlerWdata,
  output logic             trapTaken,
  output logic [W-1:0]     pcOut,
  output logic             ieOut,
  output logic             supervisorOut,
  output logic [TW-1:0]    activeThreadsOut,
  input  logic [RAW-1:0]   shRaddr,
  output logic [W-1:0]     shRdata,
  output logic [NPRED-1:0] shPredOut,
  output logic [W-1:0]     shPcOut,
  output logic             shIeOut,
  output logic             shSvOut,
  output logic [TW-1:0]    shThreadsOut
);

  trapStrobe_t strobe;
  logic        haltCur;

  trap_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .pfReq     (pfReq),
    .pfMissing (pfMissing),
    .divReq    (divReq),
    .domReq    (domReq),
    .ieCur     (ieOut),
    .haltCur   (haltCur),
    .strobe    (strobe),
    .trapTaken (trapTaken)
  );

  trap_state_dp #(
    .W(W), .NREG(NREG), .NPRED(NPRED), .NTHREADS(NTHREADS),
    .CORE_ID(CORE_ID), .LENW(LENW)
  ) uDp (
    .clk              (clk),
    .rstN             (rstN),
    .strobe           (strobe),
    .pfAddr           (pfAddr),
    .instLen          (instLen),
    .rfWe             (rfWe),
    .rfWaddr          (rfWaddr),
    .rfWdata          (rfWdata),
    .rfRaddr          (rfRaddr),
    .rfRdata          (rfRdata),
    .predWe           (predWe),
    .predWaddr        (predWaddr),
    .predWdata        (predWdata),
    .predOut          (predOut),
    .pcWe             (pcWe),
    .pcWdata          (pcWdata),
    .ieWe             (ieWe),
    .ieWdata          (ieWdata),
    .svWe             (svWe),
    .svWdata          (svWdata),
    .thrWe            (thrWe),
    .thrWdata         (thrWdata),
    .handlerWe        (handlerWe),
    .handlerWdata     (handlerWdata),
    .pcOut            (pcOut),
    .ieOut            (ieOut),
    .supervisorOut    (supervisorOut),
    .activeThreadsOut (activeThreadsOut),
    .haltCur          (haltCur),
    .shRaddr          (shRaddr),
    .shRdata          (shRdata),
    .shPredOut        (shPredOut),
    .shPcOut          (shPcOut),
    .shIeOut          (shIeOut),
    .shSvOut          (shSvOut),
    .shThreadsOut     (shThreadsOut)
  );

endmodule

// File: rtl/trap_shadow_chk.sv
module trap_shadow_chk #(
  parameter int W  = 32,
  parameter int TW = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic          trapTaken,
  input logic          ieOut,
  input logic          supervisorOut,
  input logic [TW-1:0] activeThreadsOut,
  input logic [W-1:0]  pcOut,
  input logic          shIeOut,
  input logic [TW-1:0] shThreadsOut
);

  // R4
  taken_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapTaken |=> !trapTaken);

  // R6
  handler_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapTaken |-> (supervisorOut && !ieOut && activeThreadsOut == TW'(1)));

  // R3
  disabled_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ieOut) |-> !trapTaken);

  // R5
  shadow_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapTaken |-> (shIeOut && shThreadsOut == $past(activeThreadsOut)));

  // R11
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeThreadsOut == '0) |=>
      (activeThreadsOut == '0 && $stable(pcOut) && !trapTaken));

endmodule

bind trap_shadow_unit trap_shadow_chk #(.W(W), .TW(TW)) uChk (
  .clk              (clk),
  .rstN             (rstN),
  .trapTaken        (trapTaken),
  .ieOut            (ieOut),
  .supervisorOut    (supervisorOut),
  .activeThreadsOut (activeThreadsOut),
  .pcOut            (pcOut),
  .shIeOut          (shIeOut),
  .shThreadsOut     (shThreadsOut)
);

// File: tb/sim_trap_shadow_unit.sv
`timescale 1ns/1ps
module sim_trap_shadow_unit;

  localparam int W = 32, NREG = 8, NPRED = 4, NTHREADS = 4, CORE_ID = 'h2A, LENW = 4;
  localparam int RAW = 3, PAW = 2, TW = 3;
  localparam logic [W-1:0] RST_R0 = 32'h0004_002A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic pfReq = 0, pfMissing = 0, divReq = 0, domReq = 0;
  logic [W-1:0] pfAddr = '0;
  logic [LENW-1:0] instLen = '0;
  logic rfWe = 0; logic [RAW-1:0] rfWaddr = '0, rfRaddr = '0, shRaddr = '0;
  logic [W-1:0] rfWdata = '0;
  logic predWe = 0; logic [PAW-1:0] predWaddr = '0; logic predWdata = 0;
  logic pcWe = 0; logic [W-1:0] pcWdata = '0;
  logic ieWe = 0, ieWdata = 0, svWe = 0, svWdata = 0, thrWe = 0;
  logic [TW-1:0] thrWdata = '0;
  logic handlerWe = 0; logic [W-1:0] handlerWdata = '0;
  logic [W-1:0] rfRdata, pcOut, shRdata, shPcOut;
  logic [NPRED-1:0] predOut, shPredOut;
  logic trapTaken, ieOut, supervisorOut, shIeOut, shSvOut;
  logic [TW-1:0] activeThreadsOut, shThreadsOut;

  trap_shadow_unit #(.W(W), .NREG(NREG), .NPRED(NPRED), .NTHREADS(NTHREADS),
                     .CORE_ID(CORE_ID), .LENW(LENW)) u0 (.*);

  int nRun = 0, nFail = 0;
  bit finished = 0;

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    pfReq = 0; pfMissing = 0; divReq = 0; domReq = 0; instLen = '0;
    rfWe = 0; predWe = 0; pcWe = 0; ieWe = 0; svWe = 0; thrWe = 0; handlerWe = 0;
  endtask

  task automatic rdReg(input logic [RAW-1:0] a, output logic [W-1:0] v);
    rfRaddr = a; #0.5; v = rfRdata;
  endtask

  task automatic rdShadow(input logic [RAW-1:0] a, output logic [W-1:0] v);
    shRaddr = a; #0.5; v = shRdata;
  endtask

  // Prime: traps on, user mode, 3 threads, given PC and handler, r1 marked
  task automatic prime(logic [W-1:0] pc, logic [W-1:0] hnd, logic [W-1:0] r1);
    ieWe = 1; ieWdata = 1; svWe = 1; svWdata = 0; thrWe = 1; thrWdata = 3;
    pcWe = 1; pcWdata = pc; handlerWe = 1; handlerWdata = hnd;
    rfWe = 1; rfWaddr = 1; rfWdata = r1;
    tick(); idle();
  endtask

  typedef struct packed {
    logic pf; logic miss; logic div; logic dom;
    logic [3:0] len; logic [2:0] cause; logic rewind; logic addr;
  } vec_t;

  // R7 / R8 / R9 / R10 table
  localparam vec_t VECS [7] = '{
    '{1'b1, 1'b1, 1'b0, 1'b0, 4'd4, 3'd1, 1'b1, 1'b1},
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 3'd2, 1'b1, 1'b1},
    '{1'b0, 1'b0, 1'b1, 1'b0, 4'd6, 3'd4, 1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 4'd8, 3'd5, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd3, 3'd1, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 1'b1, 4'd5, 3'd4, 1'b1, 1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 4'd7, 3'd2, 1'b1, 1'b1}
  };

  initial begin
    #400000;
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v, pc, hnd, r1;
    repeat (3) tick();
    rstN = 1; tick();

    // R1 reset state
    chk("R1 pc", pcOut, 0);
    chk("R1 ie", W'(ieOut), 0);
    chk("R1 sv", W'(supervisorOut), 1);
    chk("R1 threads", W'(activeThreadsOut), 1);
    rdReg(0, v); chk("R1 r0", v, RST_R0);
    rdReg(5, v); chk("R1 r5", v, 0);
    chk("R1 preds", W'(predOut), 0);
    chk("R1 taken", W'(trapTaken), 0);

    // R2 write ports
    rfWe = 1; rfWaddr = 2; rfWdata = 32'hA5A5_1234;
    predWe = 1; predWaddr = 2; predWdata = 1;
    pcWe = 1; pcWdata = 32'h40;
    tick(); idle();
    rdReg(2, v); chk("R2 r2 write", v, 32'hA5A5_1234);
    chk("R2 pred write", W'(predOut), 32'h4);
    chk("R2 pc write", pcOut, 32'h40);

    // R3 trap while disabled
    pfReq = 1; pfMissing = 1; pfAddr = 32'hBAD; instLen = 2;
    tick(); idle();
    chk("R3 no pulse", W'(trapTaken), 0);
    rdReg(0, v); chk("R3 r0 kept", v, RST_R0);
    chk("R3 pc kept", pcOut, 32'h40);
    chk("R3 sv kept", W'(supervisorOut), 1);

    // R5 R12 full shadow capture with concurrent write discarded
    rfWe = 1; rfWaddr = 7; rfWdata = 32'h7777_0007; tick(); idle();
    prime(32'h100, 32'h9000, 32'h1111_0001);
    domReq = 1; rfWe = 1; rfWaddr = 3; rfWdata = 32'hFFFF_FFFF;
    predWe = 1; predWaddr = 0; predWdata = 1; pcWe = 1; pcWdata = 32'h555;
    tick(); idle();
    chk("R4 pulse", W'(trapTaken), 1);
    rdShadow(0, v); chk("R5 shadow r0", v, RST_R0);
    rdShadow(1, v); chk("R5 shadow r1", v, 32'h1111_0001);
    rdShadow(2, v); chk("R5 shadow r2", v, 32'hA5A5_1234);
    rdShadow(7, v); chk("R5 shadow r7", v, 32'h7777_0007);
    chk("R5 shadow preds", W'(shPredOut), 32'h4);
    chk("R5 shadow threads", W'(shThreadsOut), 3);
    chk("R5 shadow ie", W'(shIeOut), 1);
    chk("R5 shadow sv", W'(shSvOut), 0);
    rdReg(3, v); chk("R12 r3 discarded", v, 0);
    chk("R12 pred discarded", W'(predOut), 32'h4);
    chk("R6 pc handler", pcOut, 32'h9000);
    chk("R6 threads", W'(activeThreadsOut), 1);
    chk("R6 ie", W'(ieOut), 0);
    chk("R6 sv", W'(supervisorOut), 1);
    tick();
    chk("R4 pulse ends", W'(trapTaken), 0);

    // R7 R8 R9 R10 table walk
    for (int i = 0; i < 7; i++) begin
      pc = 32'h1000 + 32'(i) * 32'h40;
      hnd = 32'h8000_0000 + 32'(i) * 32'h100;
      r1 = 32'hDEAD_0000 | 32'(i);
      prime(pc, hnd, r1);
      pfReq = VECS[i].pf; pfMissing = VECS[i].miss; divReq = VECS[i].div;
      domReq = VECS[i].dom; instLen = VECS[i].len; pfAddr = 32'hFA00_0000 | 32'(i);
      tick(); idle();
      chk("R4 taken", W'(trapTaken), 1);
      rdReg(0, v); chk("R7 R10 cause", v, W'(VECS[i].cause));
      rdReg(1, v); chk("R8 r1", v, VECS[i].addr ? (32'hFA00_0000 | 32'(i)) : r1);
      chk("R9 saved pc", shPcOut, VECS[i].rewind ? pc - W'(VECS[i].len) : pc);
      chk("R6 pc", pcOut, hnd);
    end

    // R11 halted core freezes
    prime(32'h2000, 32'h3000, 32'h0);
    thrWe = 1; thrWdata = 0; tick(); idle();
    chk("R11 threads zero", W'(activeThreadsOut), 0);
    divReq = 1; instLen = 1; pcWe = 1; pcWdata = 32'h7; rfWe = 1; rfWaddr = 4; rfWdata = 32'h44;
    tick(); idle();
    chk("R11 no pulse", W'(trapTaken), 0);
    chk("R11 pc frozen", pcOut, 32'h2000);
    rdReg(4, v); chk("R11 r4 frozen", v, 0);
    chk("R11 ie kept", W'(ieOut), 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule